// File: doc/BRIEF.md
# Multi-Cycle Shift Execution Unit

This block executes a single shift instruction. It takes a 16-bit opcode, a 32-bit operand, a 32-bit register value that may supply the shift count, and the incoming extend flag. It handles arithmetic and logical shifts in both directions. The operand may be a byte, a word or a long in register form, or a word shifted by one position in memory form. The block returns the shifted result and five condition flags: extend X, negative N, zero Z, overflow V and carry C. It stays busy for a time that grows with the shift count.

Instructions enter through a valid/ready handshake. An instruction is taken on a rising clock edge when `start_valid` and `start_ready` are both high. `start_ready` is low for the whole time the unit is busy, and any `start_valid` during that time is ignored, so a caller that keeps `start_valid` high simply waits. The completion side has no back-pressure. `done` is high for exactly one cycle. The result and flags appear at acceptance and stay unchanged until the next legal instruction is accepted, so a consumer can sample them on `done` or at any later time. Operand fetch, writeback and rotates belong to the surrounding pipeline.

Top module: `shift_exec_unit`

## Requirements
- R1: An opcode is legal in register form when bits 15:12 are 1110, bits 7:6 are not 11 and bit 4 is 0. Bit 3 selects the kind: 0 is arithmetic and 1 is logical. An opcode is legal in memory form when bits 15:12 are 1110, bits 7:6 are 11 and bits 11:10 are 00. Bit 9 selects the kind: 0 is arithmetic and 1 is logical. Any other opcode is taken by the handshake and then ignored: busy and done stay low, and the result and flags keep their values.
- R2: In register form, when opcode bit 5 is 1 the count is count_reg[5:0], giving 0 to 63. When bit 5 is 0 the count is opcode bits 11:9, and the field value 000 means a count of 8.
- R3: Opcode bit 8 selects the direction: 1 shifts left and 0 shifts right.
- R4: In register form, opcode bits 7:6 select the size: 00 is byte (8 bits), 01 is word (16 bits) and 10 is long (32 bits). Result bits above the size are copied unchanged from the operand.
- R5: An arithmetic right shift fills the vacated positions with the original sign bit, which is bit 7, 15 or 31 by size. A logical right shift and both left shifts fill with zeros. A count at or above the size therefore gives all sign copies for an arithmetic right shift and all zeros for the other shifts.
- R6: For a non-zero count, C and X both equal the last bit shifted out. This is the operand bit that passes through the sign position for a left shift and through bit 0 for a right shift. Once the count exceeds the size, this bit is 0, except for an arithmetic right shift, where it is the sign.
- R7: V is 1 after an arithmetic left shift if the sign bit takes more than one value at any point during the shift. V is 0 after every other shift.
- R8: N is the sign bit of the sized result, and Z is 1 exactly when the sized result is all zeros.
- R9: A register-supplied count of 0 leaves the result equal to the operand, clears C and V, and passes x_in to X unchanged.
- R10: The memory form always shifts bits 15:0 of the operand by one position. It ignores count_reg and opcode bits 5:0. Result bits 31:16 are copied from the operand.
- R11: After the acceptance edge of a legal instruction with count n, busy is high for exactly 2n+1 cycles and done is high only in the last of them. start_ready equals the inverse of busy, and no instruction is taken while busy.
- R12: After reset, the result and all flags are 0, busy and done are low and start_ready is high. The result and flags change only on the acceptance edge of a legal instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid | input | 1 | Instruction offered |
| start_ready | output | 1 | Unit can take an instruction (idle) |
| opcode | input | 16 | Shift instruction word |
| operand | input | 32 | Value to be shifted |
| count_reg | input | 32 | Register that may supply the count (low 6 bits used) |
| x_in | input | 1 | Current extend flag |
| result | output | 32 | Shifted value; upper bits kept from the operand |
| flag_x | output | 1 | Extend flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties watch several things on every cycle. They check that done lands exactly 2n cycles after acceptance and never lasts two cycles. They check that the result stays frozen while busy and that an illegal opcode never raises busy. They check that byte results keep the operand's upper 24 bits, that V stays low outside arithmetic left shifts, and that a zero register count clears C and V and passes X through. The actual shifted values need the bench's bit-serial model compared cycle by cycle. This covers the fill patterns, the last bit out, the sign-change overflow over long counts, the immediate 000-means-8 rule and counts taken modulo 64. Only those directed and random scenarios can show that these values are right.

// File: rtl/shx_pkg.sv
package shx_pkg;

  // Count field width: register counts are taken modulo 2**SHX_CNT_W
  localparam int SHX_CNT_W = 6;
  localparam int SHX_DATA_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10
  } shx_size_e;

  typedef struct packed {
    logic                 legal;
    logic                 left;
    logic                 arith;
    logic                 from_reg;
    shx_size_e            size;
    logic [SHX_CNT_W-1:0] count;
  } shx_cmd_t;

endpackage

// File: rtl/shx_decode.sv
module shx_decode
  import shx_pkg::*;
(
  input  logic [15:0]          opcode,
  input  logic [SHX_CNT_W-1:0] cnt_low,
  output shx_cmd_t             cmd
);

  logic is_reg_form;
  logic is_mem_form;
  logic [2:0] imm_field;
  logic unused_reg_sel;

  assign unused_reg_sel = ^opcode[2:0];
  assign imm_field      = opcode[11:9];

  always_comb begin
    is_reg_form = (opcode[15:12] == 4'hE) && (opcode[7:6] != 2'b11) && !opcode[4];
    is_mem_form = (opcode[15:12] == 4'hE) && (opcode[7:6] == 2'b11) &&
                  (opcode[11:10] == 2'b00);

    cmd.legal    = is_reg_form || is_mem_form;
    cmd.left     = opcode[8];
    cmd.arith    = is_mem_form ? !opcode[9] : !opcode[3];
    cmd.from_reg = is_reg_form && opcode[5];
    cmd.size     = is_mem_form ? SZ_WORD : shx_size_e'(opcode[7:6]);

    if (is_mem_form)
      cmd.count = SHX_CNT_W'(1);
    else if (opcode[5])
      cmd.count = cnt_low;
    else if (imm_field == 3'd0)
      cmd.count = SHX_CNT_W'(8);
    else
      cmd.count = SHX_CNT_W'(imm_field);
  end

endmodule

// File: rtl/shx_lane.sv
module shx_lane #(
  parameter int LANE_W = 16,
  parameter int CNT_W  = 6
) (
  input  logic [LANE_W-1:0] val,
  input  logic [CNT_W-1:0]  amount,
  input  logic              left,
  input  logic              arith,
  output logic [LANE_W-1:0] res,
  output logic              cout,
  output logic              ovf
);

  // Guard span wide enough that any count fetches defined fill bits
  localparam int GUARD = (1 << CNT_W) - 1;
  localparam int EXT_W = LANE_W + GUARD + 1;

  logic [EXT_W-1:0] lft_ext;
  logic [EXT_W-1:0] rgt_ext;
  logic [EXT_W-1:0] back_ext;
  logic             fill;

  always_comb begin
    fill    = arith & val[LANE_W-1];
    lft_ext = {{(GUARD + 1){1'b0}}, val} << amount;
    // one guard bit below bit 0 catches the last bit shifted out
    rgt_ext = {{GUARD{fill}}, val, 1'b0} >> amount;
    // shift the left result back arithmetically: a mismatch means a sign change
    back_ext = {{GUARD{lft_ext[LANE_W-1]}}, lft_ext[LANE_W-1:0], 1'b0} >> amount;

    res  = left ? lft_ext[LANE_W-1:0] : rgt_ext[LANE_W:1];
    cout = left ? lft_ext[LANE_W]     : rgt_ext[0];
    ovf  = left && arith && (back_ext[LANE_W:1] != val);
  end

endmodule

// File: rtl/shx_datapath.sv
module shx_datapath
  import shx_pkg::*;
(
  input  logic [SHX_DATA_W-1:0] operand,
  input  shx_cmd_t              cmd,
  input  logic                  x_in,
  output logic [SHX_DATA_W-1:0] res,
  output logic                  fx,
  output logic                  fn,
  output logic                  fz,
  output logic                  fv,
  output logic                  fc
);

  localparam int N_LANES = 3;

  logic [N_LANES-1:0][SHX_DATA_W-1:0] lane_res;
  logic [N_LANES-1:0]                 lane_c;
  logic [N_LANES-1:0]                 lane_v;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    localparam int LW = 8 << g;
    logic [LW-1:0] r;
    shx_lane #(.LANE_W(LW), .CNT_W(SHX_CNT_W)) u_lane (
      .val    (operand[LW-1:0]),
      .amount (cmd.count),
      .left   (cmd.left),
      .arith  (cmd.arith),
      .res    (r),
      .cout   (lane_c[g]),
      .ovf    (lane_v[g])
    );
    assign lane_res[g] = SHX_DATA_W'(r);
  end

  logic carry_sel;
  logic zero_cnt;

  always_comb begin
    zero_cnt = (cmd.count == '0);
    unique case (cmd.size)
      SZ_BYTE: begin
        res       = {operand[31:8], lane_res[0][7:0]};
        fn        = lane_res[0][7];
        fz        = (lane_res[0][7:0] == 8'd0);
        carry_sel = lane_c[0];
        fv        = lane_v[0];
      end
      SZ_WORD: begin
        res       = {operand[31:16], lane_res[1][15:0]};
        fn        = lane_res[1][15];
        fz        = (lane_res[1][15:0] == 16'd0);
        carry_sel = lane_c[1];
        fv        = lane_v[1];
      end
      default: begin
        res       = lane_res[2];
        fn        = lane_res[2][31];
        fz        = (lane_res[2] == 32'd0);
        carry_sel = lane_c[2];
        fv        = lane_v[2];
      end
    endcase
    fc = carry_sel;
    fx = zero_cnt ? x_in : carry_sel;
  end

endmodule

// File: rtl/shx_timer.sv
module shx_timer #(
  parameter int STEP_CYC = 2,
  parameter int CNT_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] steps,
  output logic             busy,
  output logic             done
);

  localparam int MAX_STEPS = (1 << CNT_W) - 1;
  localparam int TW        = $clog2(STEP_CYC * MAX_STEPS + 1);

  logic [TW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      remain <= TW'(steps) * TW'(STEP_CYC);
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end

  assign done = busy && (remain == '0);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done lasted two cycles"); // R11

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy) else $error("load while busy"); // R11

endmodule

// File: rtl/shift_exec_unit.sv
module shift_exec_unit
  import shx_pkg::*;
#(
  parameter int STEP_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_valid,
  output logic        start_ready,
  input  logic [15:0] opcode,
  input  logic [31:0] operand,
  input  logic [31:0] count_reg,
  input  logic        x_in,
  output logic [31:0] result,
  output logic        flag_x,
  output logic        flag_n,
  output logic        flag_z,
  output logic        flag_v,
  output logic        flag_c,
  output logic        busy,
  output logic        done
);

  localparam int MAX_STEPS = (1 << SHX_CNT_W) - 1;
  localparam int TW        = $clog2(STEP_CYC * MAX_STEPS + 1);

  shx_cmd_t cmd;
  logic [31:0] dp_res;
  logic dp_x, dp_n, dp_z, dp_v, dp_c;
  logic accept;
  logic unused_cnt_hi;

  assign unused_cnt_hi = ^count_reg[31:SHX_CNT_W];

  shx_decode u_decode (
    .opcode  (opcode),
    .cnt_low (count_reg[SHX_CNT_W-1:0]),
    .cmd     (cmd)
  );

  shx_datapath u_datapath (
    .operand (operand),
    .cmd     (cmd),
    .x_in    (x_in),
    .res     (dp_res),
    .fx      (dp_x),
    .fn      (dp_n),
    .fz      (dp_z),
    .fv      (dp_v),
    .fc      (dp_c)
  );

  assign start_ready = !busy;
  assign accept      = start_valid && start_ready && cmd.legal;

  shx_timer #(.STEP_CYC(STEP_CYC), .CNT_W(SHX_CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .steps (cmd.count),
    .busy  (busy),
    .done  (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      flag_x <= 1'b0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_v <= 1'b0;
      flag_c <= 1'b0;
    end else if (accept) begin
      result <= dp_res;
      flag_x <= dp_x;
      flag_n <= dp_n;
      flag_z <= dp_z;
      flag_v <= dp_v;
      flag_c <= dp_c;
    end
  end

  // Context kept for the properties below
  logic [SHX_CNT_W-1:0] steps_q;
  logic [TW-1:0]        elapsed;
  shx_size_e            size_q;
  logic                 asl_q;
  logic                 x_q;
  logic                 regcnt_q;
  logic [31:0]          opnd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      steps_q  <= '0;
      elapsed  <= '0;
      size_q   <= SZ_BYTE;
      asl_q    <= 1'b0;
      x_q      <= 1'b0;
      regcnt_q <= 1'b0;
      opnd_q   <= '0;
    end else if (accept) begin
      steps_q  <= cmd.count;
      elapsed  <= '0;
      size_q   <= cmd.size;
      asl_q    <= cmd.left && cmd.arith;
      x_q      <= x_in;
      regcnt_q <= cmd.from_reg;
      opnd_q   <= operand;
    end else if (busy) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> elapsed == TW'(steps_q) * TW'(STEP_CYC)) else $error("latency"); // R11

  AST_RESULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(result)) else $error("result moved while busy"); // R12

  AST_ILLEGAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready && !cmd.legal) |=> !busy) else $error("illegal taken"); // R1

  AST_BYTE_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && size_q == SZ_BYTE) |-> result[31:8] == opnd_q[31:8]) else $error("upper"); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !asl_q) |-> !flag_v) else $error("V outside ASL"); // R7

  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && regcnt_q && steps_q == '0) |-> (flag_x == x_q && !flag_c && !flag_v &&
    result == opnd_q)) else $error("zero count"); // R9

endmodule

// File: tb/test_shift_exec_unit.sv
module test_shift_exec_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [15:0] opcode = 16'h0000;
  logic [31:0] operand = 32'h0;
  logic [31:0] count_reg = 32'h0;
  logic        x_in = 1'b0;
  logic [31:0] result;
  logic        flag_x, flag_n, flag_z, flag_v, flag_c;
  logic        busy, done;

  shift_exec_unit i_shift_exec_unit (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .opcode(opcode), .operand(operand), .count_reg(count_reg), .x_in(x_in),
    .result(result), .flag_x(flag_x), .flag_n(flag_n), .flag_z(flag_z),
    .flag_v(flag_v), .flag_c(flag_c), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int    compared = 0;
  int    mismatched = 0;
  int    cyc = 0;
  string cur_req = "R12";

  // ---------------- behavioural reference ----------------
  function automatic logic ref_legal(input logic [15:0] op);
    if (op[15:12] != 4'hE) return 1'b0;
    if (op[7:6] == 2'b11) return op[11:10] == 2'b00;
    return !op[4];
  endfunction

  function automatic int ref_count(input logic [15:0] op, input logic [31:0] cr);
    if (op[7:6] == 2'b11) return 1;
    if (op[5]) return int'(cr[5:0]);
    if (op[11:9] == 3'd0) return 8;
    return int'(op[11:9]);
  endfunction

  // returns {x, n, z, v, c, result}
  function automatic logic [36:0] ref_calc(input logic [15:0] op, input logic [31:0] v,
                                           input logic [31:0] cr, input logic xi);
    int w, n;
    logic lft, ar, mem, x, c, vf, outb, sg;
    logic [31:0] mask, cur;
    mem  = (op[7:6] == 2'b11);
    w    = mem ? 16 : (op[7:6] == 2'd0 ? 8 : (op[7:6] == 2'd1 ? 16 : 32));
    lft  = op[8];
    ar   = mem ? !op[9] : !op[3];
    n    = ref_count(op, cr);
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    cur  = v & mask;
    x = xi; c = 1'b0; vf = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (lft) begin
        outb = cur[w-1];
        cur  = (cur << 1) & mask;
        if (ar && (cur[w-1] != outb)) vf = 1'b1;
      end else begin
        outb = cur[0];
        sg   = cur[w-1];
        cur  = cur >> 1;
        if (ar) cur[w-1] = sg;
      end
      c = outb;
    end
    if (n > 0) x = c;
    return {x, cur[w-1], (cur == 32'h0), vf, c, (v & ~mask) | cur};
  endfunction

  logic        m_busy = 1'b0;
  int          m_left = 0;
  logic [31:0] m_res = 32'h0;
  logic [4:0]  m_fl = 5'h0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_left = 0; m_res = 32'h0; m_fl = 5'h0;
    end else if (m_busy) begin
      if (m_left == 0) m_busy = 1'b0;
      else m_left = m_left - 1;
    end else if (start_valid && ref_legal(opcode)) begin
      {m_fl, m_res} = ref_calc(opcode, operand, count_reg, x_in);
      m_left = 2 * ref_count(opcode, count_reg);
      m_busy = 1'b1;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [2:0] act_ctl, exp_ctl;
      logic [36:0] act_dat, exp_dat;
      act_ctl = {start_ready, busy, done};
      exp_ctl = {!m_busy, m_busy, m_busy && (m_left == 0)};
      compared++;
      if (act_ctl !== exp_ctl) begin
        mismatched++;
        $display("FAIL %s cyc=%0d ready/busy/done act=%b exp=%b", cur_req, cyc, act_ctl, exp_ctl);
      end
      act_dat = {flag_x, flag_n, flag_z, flag_v, flag_c, result};
      exp_dat = {m_fl, m_res};
      compared++;
      if (act_dat !== exp_dat) begin
        mismatched++;
        $display("FAIL %s cyc=%0d xnzvc/result act=%b/%h exp=%b/%h", cur_req, cyc,
                 act_dat[36:32], act_dat[31:0], exp_dat[36:32], exp_dat[31:0]);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      mismatched++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  // register form: bits 15:12=E, 11:9 count, 8 dir, 7:6 size, 5 count source, 3 logical
  function automatic logic [15:0] mk_reg(input logic left, input logic logical,
                                         input logic [1:0] sz, input logic from_reg,
                                         input logic [2:0] cnt);
    return {4'hE, cnt, left, sz, from_reg, 1'b0, logical, 3'b010};
  endfunction

  function automatic logic [15:0] mk_mem(input logic left, input logic logical);
    return {4'hE, 2'b00, logical, left, 2'b11, 6'b010101};
  endfunction

  task automatic run(input string req, input logic [15:0] op, input logic [31:0] v,
                     input logic [31:0] cr, input logic xi);
    @(negedge clk);
    cur_req = req;
    opcode = op; operand = v; count_reg = cr; x_in = xi;
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);           // R12 reset state compared here

    // R3 direction, immediate counts
    run("R3", mk_reg(1'b1, 1'b1, 2'd1, 1'b0, 3'd3), 32'h1234_8421, 0, 1'b0);
    run("R3", mk_reg(1'b0, 1'b1, 2'd1, 1'b0, 3'd3), 32'h1234_8421, 0, 1'b0);
    // R2 immediate 000 means 8; register count modulo 64
    run("R2", mk_reg(1'b1, 1'b1, 2'd2, 1'b0, 3'd0), 32'h8123_4567, 0, 1'b0);
    run("R2", mk_reg(1'b0, 1'b1, 2'd2, 1'b1, 3'd7), 32'hF000_000F, 32'hFFFF_FFC5, 1'b0);
    // R4 size selection, upper bits kept
    run("R4", mk_reg(1'b1, 1'b0, 2'd0, 1'b0, 3'd2), 32'hAABB_CC61, 0, 1'b0);
    run("R4", mk_reg(1'b0, 1'b0, 2'd1, 1'b0, 3'd4), 32'hAABB_9CC1, 0, 1'b0);
    // R5 fill rules, including counts beyond the size
    run("R5", mk_reg(1'b0, 1'b0, 2'd0, 1'b0, 3'd3), 32'h0000_0080, 0, 1'b0);
    run("R5", mk_reg(1'b0, 1'b1, 2'd2, 1'b0, 3'd4), 32'h8000_0000, 0, 1'b0);
    run("R5", mk_reg(1'b0, 1'b0, 2'd2, 1'b1, 3'd0), 32'h8000_0001, 32'd40, 1'b0);
    run("R5", mk_reg(1'b0, 1'b0, 2'd0, 1'b1, 3'd0), 32'h0000_0091, 32'd63, 1'b0);
    // R6 last bit out into C and X
    run("R6", mk_reg(1'b1, 1'b1, 2'd0, 1'b1, 3'd0), 32'h0000_00FF, 32'd8, 1'b0);
    run("R6", mk_reg(1'b1, 1'b1, 2'd0, 1'b1, 3'd0), 32'h0000_00FF, 32'd9, 1'b1);
    run("R6", mk_reg(1'b0, 1'b1, 2'd1, 1'b0, 3'd1), 32'h0000_0003, 0, 1'b0);
    // R7 overflow only on arithmetic left with sign change
    run("R7", mk_reg(1'b1, 1'b0, 2'd1, 1'b0, 3'd1), 32'h0000_4000, 0, 1'b0);
    run("R7", mk_reg(1'b1, 1'b0, 2'd1, 1'b0, 3'd1), 32'h0000_C000, 0, 1'b0);
    run("R7", mk_reg(1'b1, 1'b0, 2'd1, 1'b0, 3'd2), 32'h0000_A000, 0, 1'b0);
    run("R7", mk_reg(1'b1, 1'b1, 2'd1, 1'b0, 3'd1), 32'h0000_4000, 0, 1'b0);
    run("R7", mk_reg(1'b1, 1'b0, 2'd2, 1'b1, 3'd0), 32'hFFFF_FFFF, 32'd33, 1'b0);
    // R8 negative and zero
    run("R8", mk_reg(1'b1, 1'b1, 2'd0, 1'b0, 3'd4), 32'h1234_5610, 0, 1'b0);
    run("R8", mk_reg(1'b1, 1'b1, 2'd0, 1'b0, 3'd3), 32'h0000_0011, 0, 1'b0);
    // R9 register count of zero
    run("R9", mk_reg(1'b1, 1'b0, 2'd2, 1'b1, 3'd5), 32'h8765_4321, 32'h0000_0040, 1'b1);
    run("R9", mk_reg(1'b0, 1'b1, 2'd1, 1'b1, 3'd5), 32'h0000_8001, 32'h0000_0000, 1'b0);
    // R10 memory form: word, one position
    run("R10", mk_mem(1'b0, 1'b0), 32'h5555_8001, 32'd17, 1'b0);
    run("R10", mk_mem(1'b1, 1'b0), 32'h5555_4001, 32'd17, 1'b1);
    run("R10", mk_mem(1'b0, 1'b1), 32'h5555_8001, 32'd17, 1'b0);
    run("R10", mk_mem(1'b1, 1'b1), 32'h5555_8000, 32'd17, 1'b0);
    // R1 illegal opcodes leave everything untouched
    run("R1", 16'hE018, 32'hDEAD_BEEF, 32'd3, 1'b1);
    run("R1", 16'hE4C0, 32'hDEAD_BEEF, 32'd3, 1'b1);
    run("R1", 16'h6000, 32'hDEAD_BEEF, 32'd3, 1'b1);

    // R11 start held high while busy: later offers must be ignored
    @(negedge clk);
    cur_req = "R11";
    opcode = mk_reg(1'b1, 1'b1, 2'd2, 1'b0, 3'd0); operand = 32'h0000_00F1;
    start_valid = 1'b1;
    @(negedge clk);
    opcode = mk_reg(1'b0, 1'b0, 2'd2, 1'b1, 3'd0); operand = 32'h8000_0000;
    count_reg = 32'd2;
    repeat (4) @(negedge clk);
    start_valid = 1'b0;
    while (m_busy) @(negedge clk);
    @(negedge clk);

    // R12 results held across idle cycles and illegal offers
    cur_req = "R12";
    run("R12", 16'hE7C0, 32'h0, 32'h0, 1'b0);
    repeat (5) @(negedge clk);

    // random sweep across R3 R4 R5 R6 R7 R8
    for (int k = 0; k < 400; k++) begin
      logic [15:0] op;
      logic [1:0]  sz;
      sz = 2'($urandom_range(0, 2));
      if ($urandom_range(0, 7) == 0)
        op = mk_mem(1'($urandom), 1'($urandom));
      else
        op = mk_reg(1'($urandom), 1'($urandom), sz, 1'($urandom), 3'($urandom));
      run("R6 sweep", op, $urandom, $urandom, 1'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule